// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of a multi-channel event timer. It watches a free-running main counter, supplied from outside together with a strobe that marks each counter advance, and emits a one-cycle fire pulse when the counter lands exactly on the programmed comparator value. The pulse goes to an interrupt router, which is outside this block. Both the channel enable and the global enable must be high for the pulse to appear.

The channel runs in one-shot or periodic mode, and it can be narrowed to the low half of the counter width. Software reaches the comparator through half-width writes with a high/low half select. In periodic mode these writes go to a hidden period register. The comparator itself is loaded only when a set-value flag is armed, and any write clears that flag. On each periodic match the period is added to the comparator, once per cycle, until the comparator is ahead of the counter.

In narrow one-shot mode the channel also handles a comparator that is behind the counter. It records this when the channel is armed and produces an extra pulse when the low half of the counter rolls over.

Top module: `evtmr_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads 0, the set-value flag reads 0 and fire_o is low.
- R2: In one-shot mode a write with wr_hi_i=0 loads the low half of the comparator, and a write with wr_hi_i=1 loads the high half; the period is not changed.
- R3: In periodic mode with the set-value flag at 0, a write loads only the selected half of the period and leaves the comparator unchanged. With the flag at 1, a low write loads the low halves of both comparator and period, and a high write loads only the comparator high half.
- R4: A pulse on setval_arm_i sets the set-value flag. Any comparator write clears the flag, and a write wins over an arm pulse in the same cycle.
- R5: Period writes clear the period's most significant bit: bit 31 of the written data on a low write in narrow mode, and bit 63 of the period on a high write.
- R6: fire_o is high for one cycle, in the cycle after a clock edge at which cnt_tick_i is high, both enables are high and the counter equals the comparator. In narrow mode only the low 32 bits are compared.
- R7: No pulse is produced when either enable is low or cnt_tick_i is low. A comparator that is behind the counter does not fire until the counter reaches it.
- R8: On a periodic match with a nonzero period, the period is added to the comparator. One more addition follows each cycle until the comparator is ahead of the counter, judged by the signed difference comparator minus counter (32-bit in narrow mode, 64-bit otherwise). With a zero period the comparator stays unchanged.
- R9: While narrow mode (narrow_i=1) is selected, the upper 32 bits of both comparator and period are held at zero, so reload sums are truncated to 32 bits.
- R10: In narrow one-shot mode the channel is armed by a comparator write or by a rise of the combined enable. If, one cycle after arming, the comparator's low half is below the counter's low half (unsigned), an extra pulse fires on the tick where the counter's low half is 0xFFFFFFFF. The match pulse still follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | CNT_W | Main counter value |
| cnt_tick_i | input | 1 | Counter holds a newly advanced value this cycle |
| glb_en_i | input | 1 | Global enable |
| ch_en_i | input | 1 | Channel enable |
| periodic_i | input | 1 | 1 = periodic mode, 0 = one-shot |
| narrow_i | input | 1 | 1 = 32-bit operation |
| setval_arm_i | input | 1 | Pulse that sets the set-value flag |
| wr_en_i | input | 1 | Comparator write strobe |
| wr_hi_i | input | 1 | 1 = write targets the high half |
| wr_data_i | input | CNT_W/2 | Write data |
| fire_o | output | 1 | Single-cycle fire pulse |
| cmp_o | output | CNT_W | Current comparator value |
| period_o | output | CNT_W | Current period value |
| setval_o | output | 1 | Current set-value flag |

## Verification
A wrong comparator or period register is visible on cmp_o and period_o one cycle after the write or reload that corrupts it. A missed or extra reload moves every later fire pulse in the same periodic sweep. A wrong pending-wrap flag only shows up at the rollover tick, as a missing or stray pulse, which can be many ticks after the arming write. The bench therefore sweeps the counter across the rollover. A catch-up loop that stops early leaves cmp_o at or behind the counter after the counter jumps, and this shows within a few idle cycles.

// File: rtl/evtmr_pkg.sv
// Shared types for the event timer comparator channel.
// Assumes nothing beyond a single clock domain.
package evtmr_pkg;
    // Channel configuration as seen by the control sequencer
    typedef struct packed {
        logic glb_en;
        logic ch_en;
        logic periodic;
        logic narrow;
    } chan_cfg_t;
endpackage

// File: rtl/evtmr_cmp_match.sv
// Combinational compare stage: equality, signed "ahead" test, low-half
// rollover detect and low-half "behind" test. Assumes CNT_W is even.
module evtmr_cmp_match #(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             narrow,
    output logic             eq,
    output logic             ahead,
    output logic             at_top,
    output logic             behind
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] diff_full;
    logic [HALF-1:0]  diff_lo;

    // Signed distance comparator minus counter in both widths
    always_comb begin
        diff_full = cmp - cnt;
        diff_lo   = cmp[HALF-1:0] - cnt[HALF-1:0];
    end

    // Mode-dependent compare results
    always_comb begin
        if (narrow) begin
            eq    = (cmp[HALF-1:0] == cnt[HALF-1:0]);
            ahead = !diff_lo[HALF-1] && (diff_lo != '0);
        end else begin
            eq    = (cmp == cnt);
            ahead = !diff_full[CNT_W-1] && (diff_full != '0);
        end
        at_top = &cnt[HALF-1:0];
        behind = (cmp[HALF-1:0] < cnt[HALF-1:0]);
    end
endmodule

// File: rtl/evtmr_cmp_regs.sv
// Comparator, period and set-value registers with the half-width write
// path, reload adder and narrow-mode truncation.
// Assumes reload is never asserted in the same cycle as a write.
module evtmr_cmp_regs #(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               periodic,
    input  logic               narrow,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic               setval_arm,
    input  logic               reload,
    output logic [CNT_W-1:0]   cmp_q,
    output logic [CNT_W-1:0]   period_q,
    output logic               setval_q
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cmp_d;
    logic [CNT_W-1:0] per_d;

    // Next-state for comparator and period
    always_comb begin
        cmp_d = cmp_q;
        per_d = period_q;
        if (wr_en) begin
            if (!periodic || setval_q) begin
                if (wr_hi) cmp_d[CNT_W-1:HALF] = wr_data;
                else       cmp_d[HALF-1:0]     = wr_data;
            end
            if (periodic) begin
                if (!wr_hi) begin
                    per_d[HALF-1:0] = wr_data;
                    if (narrow) per_d[HALF-1] = 1'b0;
                end else if (!setval_q) begin
                    per_d[CNT_W-1:HALF] = {1'b0, wr_data[HALF-2:0]};
                end
            end
        end else if (reload) begin
            cmp_d = cmp_q + period_q;
        end
        if (narrow) begin
            cmp_d[CNT_W-1:HALF] = '0;
            per_d[CNT_W-1:HALF] = '0;
        end
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '1;
            period_q <= '0;
            setval_q <= 1'b0;
        end else begin
            cmp_q    <= cmp_d;
            period_q <= per_d;
            if (wr_en)           setval_q <= 1'b0;
            else if (setval_arm) setval_q <= 1'b1;
        end
    end

    // R1
    reset_vals_chk: assert property (@(posedge clk)
        !rst_n |=> (cmp_q == '1 && period_q == '0 && !setval_q));
    // R2
    oneshot_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !periodic && !wr_hi) |=> (cmp_q[HALF-1:0] == $past(wr_data)));
    // R4
    setval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !setval_q);
    // R5
    period_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_q[CNT_W-1]);
    // R9
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |=> (cmp_q[CNT_W-1:HALF] == '0 && period_q[CNT_W-1:HALF] == '0));
endmodule

// File: rtl/evtmr_cmp_seq.sv
// Control sequencer: match and rollover pulses, periodic catch-up
// reload, arming and the pending-rollover flag.
// Assumes compare inputs are valid in the cycle they are sampled.
module evtmr_cmp_seq
    import evtmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    input  logic      tick,
    input  logic      wr_en,
    input  logic      period_nz,
    input  logic      eq,
    input  logic      ahead,
    input  logic      at_top,
    input  logic      behind,
    output logic      reload,
    output logic      fire_q
);
    logic en_all, en_q, arm_q, pend_q, catch_q, narrow_os, hit, wrap_hit;

    // Qualified events for this cycle
    always_comb begin
        en_all    = cfg.glb_en && cfg.ch_en;
        narrow_os = cfg.narrow && !cfg.periodic;
        hit       = tick && en_all && eq;
        wrap_hit  = tick && en_all && narrow_os && pend_q && at_top;
        reload    = !wr_en && cfg.periodic && period_nz &&
                    (hit || (catch_q && !ahead));
    end

    // Pulse, arming, catch-up and pending-rollover state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            arm_q   <= 1'b0;
            pend_q  <= 1'b0;
            catch_q <= 1'b0;
            fire_q  <= 1'b0;
        end else begin
            en_q    <= en_all;
            arm_q   <= wr_en || (en_all && !en_q);
            catch_q <= reload;
            fire_q  <= hit || wrap_hit;
            if (!narrow_os || !en_all) pend_q <= 1'b0;
            else if (arm_q)            pend_q <= behind;
            else if (wrap_hit)         pend_q <= 1'b0;
        end
    end

    // R10
    pend_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> $past(narrow_os && en_all));
endmodule

// File: rtl/evtmr_cmp_channel.sv
// Top of one event timer comparator channel. Wires the compare stage,
// register file and sequencer. Assumes cnt_i advances at most once per
// cnt_tick_i and that CNT_W is even.
module evtmr_cmp_channel
    import evtmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               cnt_tick_i,
    input  logic               glb_en_i,
    input  logic               ch_en_i,
    input  logic               periodic_i,
    input  logic               narrow_i,
    input  logic               setval_arm_i,
    input  logic               wr_en_i,
    input  logic               wr_hi_i,
    input  logic [CNT_W/2-1:0] wr_data_i,
    output logic               fire_o,
    output logic [CNT_W-1:0]   cmp_o,
    output logic [CNT_W-1:0]   period_o,
    output logic               setval_o
);
    chan_cfg_t cfg;
    logic eq, ahead, at_top, behind, reload;

    // Pack configuration inputs
    always_comb begin
        cfg.glb_en   = glb_en_i;
        cfg.ch_en    = ch_en_i;
        cfg.periodic = periodic_i;
        cfg.narrow   = narrow_i;
    end

    evtmr_cmp_match #(.CNT_W(CNT_W)) u_match (
        .cnt(cnt_i), .cmp(cmp_o), .narrow(narrow_i),
        .eq(eq), .ahead(ahead), .at_top(at_top), .behind(behind)
    );

    evtmr_cmp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .periodic(periodic_i), .narrow(narrow_i),
        .wr_en(wr_en_i), .wr_hi(wr_hi_i), .wr_data(wr_data_i),
        .setval_arm(setval_arm_i), .reload(reload),
        .cmp_q(cmp_o), .period_q(period_o), .setval_q(setval_o)
    );

    evtmr_cmp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick(cnt_tick_i),
        .wr_en(wr_en_i), .period_nz(period_o != '0), .eq(eq), .ahead(ahead),
        .at_top(at_top), .behind(behind), .reload(reload), .fire_q(fire_o)
    );

    // R7
    fire_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(glb_en_i && ch_en_i && cnt_tick_i));
endmodule

// File: tb/tb_evtmr_cmp_channel.sv
module tb_evtmr_cmp_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        tick = 1'b0, glb = 1'b0, ch = 1'b0, per = 1'b0, nar = 1'b0;
    logic        arm = 1'b0, wr = 1'b0, hi = 1'b0;
    logic [31:0] wd = '0;
    logic        fire;
    logic [63:0] cmp, period;
    logic        setval;
    int          checks = 0, fails = 0, nfire;
    bit          done = 0;
    logic [63:0] m_cmp, m_per;
    bit          m_pend;

    always #5 clk = ~clk;

    evtmr_cmp_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_tick_i(tick),
        .glb_en_i(glb), .ch_en_i(ch), .periodic_i(per), .narrow_i(nar),
        .setval_arm_i(arm), .wr_en_i(wr), .wr_hi_i(hi), .wr_data_i(wd),
        .fire_o(fire), .cmp_o(cmp), .period_o(period), .setval_o(setval)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wrt(input bit h, input logic [31:0] d);
        wr = 1'b1; hi = h; wd = d;
        @(negedge clk);
        wr = 1'b0; hi = 1'b0;
    endtask

    task automatic pulse_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // Tick across n counter values; model predicts each pulse
    task automatic sweep(input logic [63:0] start, input int n, input string tag);
        nfire = 0;
        for (int i = 0; i < n; i++) begin
            logic [63:0] c;
            bit eqm, wrm, expf;
            c = start + 64'(i);
            eqm = nar ? (c[31:0] == m_cmp[31:0]) : (c == m_cmp);
            wrm = nar && !per && m_pend && (c[31:0] == 32'hFFFF_FFFF);
            expf = eqm || wrm;
            if (wrm) m_pend = 0;
            if (eqm && per && m_per != 0) begin
                m_cmp = m_cmp + m_per;
                if (nar) m_cmp[63:32] = '0;
            end
            cnt = c; tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (fire) nfire++;
            chk(fire == expf, tag, 64'(fire), 64'(expf));
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired (R1 run incomplete) actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        chk(cmp == '1, "R1 cmp", cmp, '1);
        chk(period == '0, "R1 period", period, '0);
        chk(!setval && !fire, "R1 flags", {62'd0, setval, fire}, '0);
        rst_n = 1'b1;
        idle(1);

        // R2 one-shot writes by half
        wrt(0, 32'h10);
        chk(cmp == 64'hFFFF_FFFF_0000_0010, "R2 low half", cmp, 64'hFFFF_FFFF_0000_0010);
        wrt(1, 32'h0);
        chk(cmp == 64'h10, "R2 high half", cmp, 64'h10);
        chk(period == '0, "R2 period untouched", period, '0);

        // R6 match sweep, one-shot 64-bit
        glb = 1; ch = 1;
        idle(2);
        m_cmp = 64'h10; m_per = 0; m_pend = 0;
        sweep(64'h8, 16, "R6 one-shot match");

        // R7 qualification
        wrt(0, 32'h20);
        cnt = 64'h20; glb = 0; tick = 1; @(negedge clk); tick = 0;
        chk(!fire, "R7 global enable low", 64'(fire), 0);
        glb = 1; ch = 0; tick = 1; @(negedge clk); tick = 0;
        chk(!fire, "R7 channel enable low", 64'(fire), 0);
        ch = 1; tick = 0; @(negedge clk);
        chk(!fire, "R7 no tick", 64'(fire), 0);
        wrt(0, 32'h5);
        idle(2);
        m_cmp = 64'h5;
        sweep(64'h8, 8, "R7 behind comparator");

        // R3 periodic writes without set-value
        per = 1;
        wrt(0, 32'h7);
        chk(period == 64'h7, "R3 period low", period, 64'h7);
        chk(cmp == 64'h5, "R3 cmp kept", cmp, 64'h5);
        // R4 arm and clear
        pulse_arm();
        chk(setval, "R4 arm sets", 64'(setval), 1);
        wrt(0, 32'h100);
        chk(!setval, "R4 write clears", 64'(setval), 0);
        chk(cmp == 64'h100 && period == 64'h100, "R3 set-value low write", cmp, 64'h100);
        wrt(0, 32'h7);
        // R5 high period write masks bit 63
        wrt(1, 32'hFFFF_FFFF);
        chk(period == 64'h7FFF_FFFF_0000_0007, "R5 period msb", period, 64'h7FFF_FFFF_0000_0007);
        chk(cmp == 64'h100, "R3 high write cmp kept", cmp, 64'h100);
        wrt(1, 32'h0);
        // R4 write wins over arm in same cycle
        arm = 1; wrt(0, 32'h7); arm = 0;
        chk(!setval, "R4 write beats arm", 64'(setval), 0);

        // R8 periodic reload sweep
        m_cmp = 64'h100; m_per = 64'h7;
        sweep(64'hF0, 80, "R8 periodic reload");
        chk(cmp == m_cmp, "R8 cmp after sweep", cmp, m_cmp);

        // R8 catch-up after counter jump
        pulse_arm();
        wrt(0, 32'h200);
        wrt(0, 32'h10);
        cnt = 64'h200; tick = 1; @(negedge clk); tick = 0;
        chk(fire, "R8 match at 0x200", 64'(fire), 1);
        cnt = 64'h235;
        idle(8);
        chk(cmp == 64'h240, "R8 catch-up result", cmp, 64'h240);

        // R8 zero period leaves comparator
        wrt(0, 32'h0);
        cnt = 64'h240; tick = 1; @(negedge clk); tick = 0;
        chk(fire, "R8 zero period fire", 64'(fire), 1);
        idle(2);
        chk(cmp == 64'h240, "R8 zero period cmp", cmp, 64'h240);

        // R9 narrow clamp
        per = 0;
        wrt(1, 32'h5);
        chk(cmp == 64'h5_0000_0240, "R2 high half again", cmp, 64'h5_0000_0240);
        nar = 1;
        idle(1);
        chk(cmp == 64'h240, "R9 upper cleared", cmp, 64'h240);

        // R5 narrow low period write masks bit 31
        per = 1;
        wrt(0, 32'hFFFF_FFF0);
        chk(period == 64'h7FFF_FFF0, "R5 narrow period", period, 64'h7FFF_FFF0);
        pulse_arm();
        wrt(0, 32'hFFFF_FFF8);
        chk(cmp == 64'hFFFF_FFF8, "R3 narrow set-value", cmp, 64'hFFFF_FFF8);
        wrt(0, 32'h10);
        cnt = 64'h3_FFFF_FFF8; tick = 1; @(negedge clk); tick = 0;
        chk(fire, "R6 narrow match", 64'(fire), 1);
        idle(3);
        chk(cmp == 64'h8, "R9 truncated reload", cmp, 64'h8);

        // R10 rollover pulse when comparator behind
        per = 0;
        cnt = 64'hFFFF_FF00;
        wrt(0, 32'h50);
        idle(2);
        m_cmp = 64'h50; m_per = 0; m_pend = 1;
        sweep(64'hFFFF_FFF0, 112, "R10 rollover then match");
        chk(nfire == 2, "R10 pulse count", 64'(nfire), 2);

        // R10 no rollover pulse when comparator ahead
        cnt = 64'hFFFF_FF00;
        wrt(0, 32'hFFFF_FF80);
        idle(2);
        m_cmp = 64'hFFFF_FF80; m_pend = 0;
        sweep(64'hFFFF_FF70, 256, "R10 no rollover");
        chk(nfire == 1, "R10 single pulse", 64'(nfire), 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule